// File: doc/BRIEF.md
# Flash Write-Status Polling Generator

This block produces the status byte that a flash device returns to a host while an embedded program or erase runs inside it. The command decoder sends it a start pulse together with the target address, the byte being written, whether the operation is an erase, and whether the device is currently in erase suspend. The internal write algorithm later reports either completion or failure. Between those two points the host polls with read requests, and the block answers each read with a status byte in the following cycle.

Three status bits are modelled. Bit 7 is the polling bit: during a program it is the inverse of the data being written, and it becomes the true data once the program completes. Bit 6 flips on every status read while the operation is busy. Bit 5 flags a failure and stays set until a return-to-array command arrives. An active-low ready/busy pin shows whether an operation is in progress. For a settling window after the start pulse, every read is marked as not valid.

Read data is registered. A read request sampled on a clock edge updates `st_byte` on that same edge, and raises `st_valid` for exactly one cycle when the answer is meaningful. `st_byte` keeps its value until the next read request.

Top module: `fsp_status_poller`

## Requirements
- R1: After reset, `rb_n` is 1, `st_valid` is 0 and `st_byte` is 8'h00.
- R2: A start is accepted only when no operation is running and no failure is pending. After an accepted start, `rb_n` goes low from the next cycle. A start is ignored in the following cases, and leaves the running operation, its latched data and `rb_n` unchanged:
  - while a program or erase runs;
  - while a failure is pending;
  - when it requests an erase while `sus_mode` is high.
- R3: After an accepted start on edge k, the settling counter is loaded with SETTLE_CYC. Reads sampled on edges k+1 through k+SETTLE_CYC return `st_valid`=0 and `st_byte`=8'h00. The first valid read is the one sampled on edge k+SETTLE_CYC+1.
- R4: While a program runs, a valid read at any address returns bit 7 equal to the complement of bit 7 of the programmed byte. This holds whatever `sus_mode` was at start. Bits 4..0 read 0.
- R5: While an erase runs, bit 7 of every valid status read is 0.
- R6: Bit 6 is 1 on the first valid read of a running operation and inverts on each further valid read until the operation ends. Reads that fall inside the settling window do not advance it. After completion, repeated reads return an identical byte.
- R7: After a program completes, `rb_n` is 1. A read at the programmed address returns the full programmed byte with `st_valid`=1.
- R8: After a program completes, a read at any other address returns `st_valid`=0 and 8'h00. After an erase completes, a read at any address returns 8'hFF with `st_valid`=1.
- R9: A failure pulse during a running operation sets bit 5. The block then stays in that state, with `rb_n` low and bit 6 still toggling, and ignores completion pulses. It leaves only on `ret_array`, which returns it to array reading.
- R10: In array-read mode (after reset or after `ret_array`), reads return `st_valid`=0, and completion or failure pulses have no effect on `rb_n` or on later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_go | input | 1 | Start pulse, coincident with the last write pulse of the command |
| wr_addr | input | AW | Target address of the operation |
| wr_data | input | 8 | Byte being programmed |
| wr_is_erase | input | 1 | 1 = erase operation, 0 = program |
| sus_mode | input | 1 | Device is in erase suspend |
| alg_done | input | 1 | Embedded algorithm finished |
| alg_err | input | 1 | Embedded algorithm failed |
| rd_req | input | 1 | Host status read request |
| rd_addr | input | AW | Host read address |
| ret_array | input | 1 | Return-to-array-read command pulse |
| st_byte | output | 8 | Status byte of the last read |
| st_valid | output | 1 | One-cycle flag, last read carried meaningful status |
| rb_n | output | 1 | Ready/busy, low while an operation runs or a failure is pending |

## Verification
The bench builds the block with an 8-bit address and SETTLE_CYC set to 4, instead of the few hundred cycles a 4 µs window needs. With this setting a read can be placed on the last invalid edge and on the first valid edge of the settling window. The same short window lets every operation in the vector table reach completion within a few cycles. A large window would hide that boundary behind long idle stretches, so the short value is what makes the off-by-one case directly testable.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_END  = 2'd2,
    PH_ERR  = 2'd3
  } phase_t;

  // Polling bit while the operation is still running.
  function automatic logic poll_bit(input logic is_erase, input logic d7);
    if (is_erase) return 1'b0;
    return ~d7;
  endfunction

  // Assemble a status byte from the three modelled bits.
  function automatic logic [7:0] pack_status(input logic b7, input logic b6,
                                             input logic b5);
    return {b7, b6, b5, 5'b0_0000};
  endfunction

endpackage

// File: rtl/fsp_settle_timer.sv
module fsp_settle_timer #(
  parameter int unsigned CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic settled
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (arm)        cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign settled = (cnt == '0);
endmodule

// File: rtl/fsp_op_tracker.sv
module fsp_op_tracker
  import fsp_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  input  logic [7:0]    go_data,
  input  logic          go_erase,
  input  logic          sus,
  input  logic          done,
  input  logic          err,
  input  logic          clr,
  output phase_t        phase,
  output logic [AW-1:0] t_addr,
  output logic [7:0]    t_data,
  output logic          t_erase,
  output logic          accept
);
  phase_t nxt;

  assign accept = go && (phase == PH_IDLE || phase == PH_END) && !(go_erase && sus);

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (accept) nxt = PH_RUN;
      PH_RUN:  if (err) nxt = PH_ERR; else if (done) nxt = PH_END;
      PH_END:  if (accept) nxt = PH_RUN; else if (clr) nxt = PH_IDLE;
      PH_ERR:  if (clr) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      t_addr  <= '0;
      t_data  <= '0;
      t_erase <= 1'b0;
    end else begin
      phase <= nxt;
      if (accept) begin
        t_addr  <= go_addr;
        t_data  <= go_data;
        t_erase <= go_erase;
      end
    end
  end
endmodule

// File: rtl/fsp_status_former.sv
module fsp_status_former
  import fsp_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] t_addr,
  input  logic [7:0]    t_data,
  input  logic          t_erase,
  input  logic          settled,
  input  logic          arm,
  output logic [7:0]    st_byte,
  output logic          st_valid,
  output logic          busy_rd
);
  logic       tog;
  logic       live;
  logic       hit;
  logic [7:0] nb;
  logic       nv;

  assign live    = (phase == PH_RUN) || (phase == PH_ERR);
  assign hit     = (rd_addr == t_addr);
  assign busy_rd = rd_req && settled && live;

  always_comb begin
    nb = 8'h00;
    nv = 1'b0;
    unique case (phase)
      PH_RUN, PH_ERR: begin
        nv = 1'b1;
        nb = pack_status(poll_bit(t_erase, t_data[7]), ~tog, phase == PH_ERR);
      end
      PH_END: begin
        if (t_erase) begin
          nv = 1'b1;
          nb = 8'hFF;
        end else if (hit) begin
          nv = 1'b1;
          nb = t_data;
        end
      end
      default: begin
        nv = 1'b0;
        nb = 8'h00;
      end
    endcase
    if (!settled) begin
      nv = 1'b0;
      nb = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog      <= 1'b0;
      st_byte  <= 8'h00;
      st_valid <= 1'b0;
    end else begin
      if (arm)          tog <= 1'b0;
      else if (busy_rd) tog <= ~tog;
      st_valid <= rd_req && nv;
      if (rd_req) st_byte <= nb;
    end
  end
endmodule

// File: rtl/fsp_status_poller.sv
module fsp_status_poller
  import fsp_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned SETTLE_CYC = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          wr_is_erase,
  input  logic          sus_mode,
  input  logic          alg_done,
  input  logic          alg_err,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          ret_array,
  output logic [7:0]    st_byte,
  output logic          st_valid,
  output logic          rb_n
);
  phase_t        phase;
  logic [AW-1:0] t_addr;
  logic [7:0]    t_data;
  logic          t_erase;
  logic          accept;
  logic          settled;
  logic          busy_rd;
  logic          in_fail;

  fsp_op_tracker #(.AW(AW)) u_trk (
    .clk(clk), .rst_n(rst_n), .go(wr_go), .go_addr(wr_addr), .go_data(wr_data),
    .go_erase(wr_is_erase), .sus(sus_mode), .done(alg_done), .err(alg_err),
    .clr(ret_array), .phase(phase), .t_addr(t_addr), .t_data(t_data),
    .t_erase(t_erase), .accept(accept)
  );

  fsp_settle_timer #(.CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .arm(accept), .settled(settled)
  );

  fsp_status_former #(.AW(AW)) u_fmt (
    .clk(clk), .rst_n(rst_n), .phase(phase), .rd_req(rd_req), .rd_addr(rd_addr),
    .t_addr(t_addr), .t_data(t_data), .t_erase(t_erase), .settled(settled),
    .arm(accept), .st_byte(st_byte), .st_valid(st_valid), .busy_rd(busy_rd)
  );

  assign in_fail = (phase == PH_ERR);
  assign rb_n    = !((phase == PH_RUN) || in_fail);
endmodule

// File: rtl/fsp_status_poller_chk.sv
module fsp_status_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       busy_rd,
  input logic       in_fail,
  input logic       ret_array,
  input logic       rb_n,
  input logic       t_erase,
  input logic [7:0] t_data,
  input logic [7:0] st_byte,
  input logic       st_valid
);
  // R2: an accepted start drives ready/busy low on the next cycle
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rb_n);

  // R3: the read right after the start edge still falls in the settling window
  a_r3_settle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 !st_valid);

  // R4: program polling bit is inverted while running
  a_r4_prog_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && !t_erase) |=> (st_valid && st_byte[7] != t_data[7]
                               && st_byte[4:0] == 5'b0));

  // R5: erase polling bit reads 0 while running
  a_r5_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && t_erase) |=> (st_valid && !st_byte[7]));

  // R6: back-to-back busy reads return opposite toggle bits
  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && $past(busy_rd)) |=> (st_byte[6] != $past(st_byte[6])));

  // R9: failure state persists until the return command
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fail && !ret_array) |=> in_fail);

  // R9: ready/busy stays low while failure is pending
  a_r9_fail_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_fail |-> !rb_n);
endmodule

bind fsp_status_poller fsp_status_poller_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy_rd(busy_rd),
  .in_fail(in_fail), .ret_array(ret_array), .rb_n(rb_n), .t_erase(t_erase),
  .t_data(t_data), .st_byte(st_byte), .st_valid(st_valid)
);

// File: tb/fsp_status_poller_test.sv
module fsp_status_poller_test;
  localparam int unsigned AW = 8;
  localparam int unsigned SC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_go = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          wr_is_erase = 1'b0;
  logic          sus_mode = 1'b0;
  logic          alg_done = 1'b0;
  logic          alg_err = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          ret_array = 1'b0;
  logic [7:0]    st_byte;
  logic          st_valid;
  logic          rb_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fsp_status_poller #(.AW(AW), .SETTLE_CYC(SC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_is_erase(wr_is_erase), .sus_mode(sus_mode), .alg_done(alg_done),
    .alg_err(alg_err), .rd_req(rd_req), .rd_addr(rd_addr), .ret_array(ret_array),
    .st_byte(st_byte), .st_valid(st_valid), .rb_n(rb_n)
  );

  // {erase, susp, data, addr, first busy byte, done byte}
  localparam logic [41:0] VEC [5] = '{
    {1'b0, 1'b0, 8'hA5, 8'h10, 8'h40, 8'hA5, 8'h00},
    {1'b0, 1'b1, 8'h3C, 8'h22, 8'hC0, 8'h3C, 8'h00},
    {1'b1, 1'b0, 8'h00, 8'h05, 8'h40, 8'hFF, 8'hFF},
    {1'b0, 1'b0, 8'h7F, 8'hFF, 8'hC0, 8'h7F, 8'h00},
    {1'b0, 1'b1, 8'h80, 8'h00, 8'h40, 8'h80, 8'h00}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b byte=%02h, expected valid=%0b byte=%02h",
               tag, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic chk_rb(input string tag, input logic exp);
    checks++;
    if (rb_n !== exp) begin
      errors++;
      $display("FAIL %s: rb_n got %0b expected %0b", tag, rb_n, exp);
    end
  endtask

  task automatic start(input logic er, input logic su, input logic [7:0] d,
                       input logic [AW-1:0] a);
    wr_go = 1'b1; wr_is_erase = er; sus_mode = su; wr_data = d; wr_addr = a;
    tick();
    wr_go = 1'b0; sus_mode = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    rd_req = 1'b1; rd_addr = a;
    tick();
    rd_req = 1'b0;
  endtask

  task automatic pulse_done();
    alg_done = 1'b1; tick(); alg_done = 1'b0;
  endtask

  task automatic pulse_err();
    alg_err = 1'b1; tick(); alg_err = 1'b0;
  endtask

  task automatic pulse_ret();
    ret_array = 1'b1; tick(); ret_array = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {st_valid, st_byte}, 9'h000);
    chk_rb("R1 reset rb_n", 1'b1);
    rst_n = 1'b1;
    tick();

    // Vector table
    for (int i = 0; i < 5; i++) begin
      logic          er, su;
      logic [7:0]    d, bb, db, ob;
      logic [AW-1:0] a;
      {er, su, d, a, bb, db, ob} = VEC[i];
      start(er, su, d, a);
      chk_rb("R2 busy after start", 1'b0);
      repeat (SC) tick();
      rd(a);
      chk(er ? "R5 erase busy read" : "R4 program busy read", {st_valid, st_byte}, {1'b1, bb});
      rd(a ^ 8'h01);
      chk("R6 toggle on other address", {st_valid, st_byte}, {1'b1, bb ^ 8'h40});
      pulse_done();
      chk_rb("R7 ready after done", 1'b1);
      rd(a);
      chk("R7 done read at address", {st_valid, st_byte}, {1'b1, db});
      rd(a);
      chk("R6 stable after done", {st_valid, st_byte}, {1'b1, db});
      rd(a ^ 8'h01);
      chk("R8 done other address", {st_valid, st_byte}, {er, ob});
      pulse_ret();
      rd(a);
      chk("R10 array read after return", {st_valid, 8'h00}, 9'h000);
    end

    // R10 pulses in array mode are ignored
    pulse_done();
    pulse_err();
    chk_rb("R10 pulses ignored rb_n", 1'b1);
    rd(8'h33);
    chk("R10 idle read", {st_valid, st_byte}, 9'h000);

    // R3 settling boundary
    start(1'b0, 1'b0, 8'h00, 8'h33);
    rd(8'h33);
    chk("R3 read at k+1", {st_valid, st_byte}, 9'h000);
    repeat (2) tick();
    rd(8'h33);
    chk("R3 read at k+SETTLE", {st_valid, st_byte}, 9'h000);
    rd(8'h33);
    chk("R3 first valid read", {st_valid, st_byte}, {1'b1, 8'hC0});

    // R2 start ignored while running
    start(1'b0, 1'b0, 8'h80, 8'h44);
    rd(8'h33);
    chk("R2 start ignored while busy", {st_valid, st_byte}, {1'b1, 8'h80});

    // R9 failure
    pulse_err();
    rd(8'h33);
    chk("R9 fail bit set", {st_valid, st_byte}, {1'b1, 8'hE0});
    chk_rb("R9 busy during fail", 1'b0);
    pulse_done();
    start(1'b0, 1'b0, 8'h00, 8'h33);
    rd(8'h33);
    chk("R9 done and start ignored in fail", {st_valid, st_byte}, {1'b1, 8'hA0});
    chk_rb("R9 still busy", 1'b0);
    pulse_ret();
    chk_rb("R9 return clears", 1'b1);
    rd(8'h33);
    chk("R9 array after return", {st_valid, st_byte}, 9'h000);

    // R2 erase refused during erase suspend
    start(1'b1, 1'b1, 8'h00, 8'h05);
    chk_rb("R2 erase in suspend ignored", 1'b1);
    repeat (SC + 1) tick();
    rd(8'h05);
    chk("R2 erase in suspend no status", {st_valid, st_byte}, 9'h000);

    finish_run();
  end
endmodule